// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash interface and decides when an embedded program or erase operation inside the flash device has finished. After the command sequence has been written by other logic, a one-cycle `start` pulse makes the poller issue status reads over a request/acknowledge read port. It compares the selected toggle bit across each pair of back-to-back reads. It also looks at the time-limit bit in the most recent read.

Two equal toggle values in a pair end the job with a one-cycle `done` pulse. A changing toggle bit with the time-limit bit clear starts a fresh pair. A changing toggle bit with the time-limit bit set starts one confirming pair. The confirming pair is needed because toggling may stop in the same instant that the time-limit bit rises. If the toggle bit still changes in that confirming pair, the poller writes the reset command (0xF0 to a fixed address) over a request/acknowledge write port and then pulses `fail`.

An `abort` pulse drops any pass in progress at any time. The next `start` begins again from the first read of a new pair. A parameter picks which status bit is compared: bit 6, which toggles on any busy read, or bit 2, which toggles only in sectors selected for erase.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `rd_req`, `wr_req`, `done`, `fail` and `busy` are all low.
- R2: A `start` pulse while idle raises `busy` and `rd_req` in the next cycle. A `start` while busy has no effect on the sequence of reads or on the outcome.
- R3: `rd_req` stays high until a cycle with `rd_ack` high, and each such cycle consumes exactly one read. A decision is taken only on the second read of a pair, never on a single read.
- R4: If the toggle bit in the second read of a pair equals that of the first read, `done` is high in the cycle after the second acknowledge, `busy` is low in that same cycle, and no further read is requested.
- R5: If the toggle bit differs within a pair and bit 5 of the second read is 0, a new pair begins: `rd_req` is high in the cycle after the acknowledge.
- R6: If the toggle bit differs within a pair and bit 5 of the second read is 1, one confirming pair follows. Only bit 5 of the latest read counts. An equal toggle bit in the confirming pair gives `done`.
- R7: If the toggle bit differs in the confirming pair, `wr_req` rises in the next cycle with `wr_addr` = RESET_ADDR (default 0) and `wr_data` = 0xF0. It stays high until `wr_ack`, and `rd_req` stays low while it is high.
- R8: `done` and `fail` are single-cycle pulses and never high together. `fail` follows the cycle in which `wr_ack` completes the reset write.
- R9: `abort` returns the block to idle in the next cycle with no request pending. It clears both the stored first toggle value and the confirming state, so the next `start` begins a fresh two-read pass.
- R10: Parameter TOGGLE_SEL = 6 compares bit 6 of the read data and TOGGLE_SEL = 2 compares bit 2. The unselected toggle bit has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling pass (used only when idle) |
| abort | input | 1 | Abandon polling and return to idle |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read accepted; rd_data valid this cycle |
| rd_data | input | 8 | Status byte returned by the device |
| wr_req | output | 1 | Reset-command write request |
| wr_ack | input | 1 | Reset write accepted |
| wr_addr | output | AW | Address of the reset-command write |
| wr_data | output | 8 | Data of the reset-command write (0xF0) |
| busy | output | 1 | A polling pass or reset write is in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| fail | output | 1 | One-cycle pulse: operation failed, reset written |

## Verification
A lost or stale first toggle value would show up as `done` after a pair that differs, or as a repoll after a pair that matches. Either error appears in the cycle right after the second acknowledge. A confirming flag that is never set or never cleared would show as a reset write where a repoll was due, or a repoll where a write was due, one cycle after the deciding read. The directed scenarios therefore sample `rd_req`, `wr_req`, `done` and `fail` in the exact cycle after each acknowledge. Around `abort` they choose data patterns so that any state left behind from before the abort would change the next decision.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_A   = 2'd1,
    ST_RD_B   = 2'd2,
    ST_RST_WR = 2'd3
  } tpc_state_e;

  typedef enum logic [1:0] {
    VD_DONE    = 2'd0,
    VD_REPOLL  = 2'd1,
    VD_CONFIRM = 2'd2,
    VD_FAIL    = 2'd3
  } tpc_verdict_e;

  // Decide the outcome of a read pair from the two toggle samples, the
  // time-limit bit of the latest read and whether this was a confirming pair.
  function automatic tpc_verdict_e judge_pair(input logic first_t,
                                              input logic second_t,
                                              input logic limit_hi,
                                              input logic confirming);
    tpc_verdict_e v;
    if (first_t == second_t)  v = VD_DONE;
    else if (confirming)      v = VD_FAIL;
    else if (limit_hi)        v = VD_CONFIRM;
    else                      v = VD_REPOLL;
    return v;
  endfunction

endpackage

// File: rtl/tpc_sample.sv
module tpc_sample #(
  parameter int unsigned DW         = 8,
  parameter int unsigned TOGGLE_SEL = 6,
  parameter int unsigned LIMIT_SEL  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cap_first,
  input  logic          cap_second,
  input  logic [DW-1:0] rd_data,
  output logic          first_bit,
  output logic          first_valid,
  output logic          cur_bit,
  output logic          cur_limit
);
  localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [IW-1:0] LIM_IDX = IW'(LIMIT_SEL);

  generate
    if (TOGGLE_SEL == 2) begin : gen_sel_sector
      assign cur_bit = rd_data[2];
    end else begin : gen_sel_device
      assign cur_bit = rd_data[6];
    end
  endgenerate

  assign cur_limit = rd_data[LIM_IDX];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      first_bit   <= 1'b0;
      first_valid <= 1'b0;
    end else if (cap_first) begin
      first_bit   <= cur_bit;
      first_valid <= 1'b1;
    end else if (cap_second) begin
      first_valid <= 1'b0;
    end
  end

  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    cap_second |-> first_valid) else $error("second read without first"); // R3
  AST_NO_DOUBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cap_first |-> !first_valid) else $error("first read captured twice"); // R3

endmodule

// File: rtl/tpc_fsm.sv
module tpc_fsm
  import tpc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic         rd_ack,
  input  logic         wr_ack,
  input  tpc_verdict_e verdict,
  output logic         rd_req,
  output logic         wr_req,
  output logic         busy,
  output logic         done,
  output logic         fail,
  output logic         confirming,
  output logic         cap_first,
  output logic         cap_second,
  output logic         clear
);
  tpc_state_e state, state_nx;
  logic       conf_nx, done_nx, fail_nx;

  assign rd_req = (state == ST_RD_A) || (state == ST_RD_B);
  assign wr_req = (state == ST_RST_WR);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    state_nx   = state;
    conf_nx    = confirming;
    done_nx    = 1'b0;
    fail_nx    = 1'b0;
    cap_first  = 1'b0;
    cap_second = 1'b0;
    clear      = 1'b0;
    if (abort) begin
      state_nx = ST_IDLE;
      conf_nx  = 1'b0;
      clear    = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          conf_nx = 1'b0;
          if (start) state_nx = ST_RD_A;
        end
        ST_RD_A: if (rd_ack) begin
          cap_first = 1'b1;
          state_nx  = ST_RD_B;
        end
        ST_RD_B: if (rd_ack) begin
          cap_second = 1'b1;
          case (verdict)
            VD_DONE:    begin state_nx = ST_IDLE;   done_nx = 1'b1; conf_nx = 1'b0; end
            VD_CONFIRM: begin state_nx = ST_RD_A;   conf_nx = 1'b1; end
            VD_FAIL:    begin state_nx = ST_RST_WR; conf_nx = 1'b0; end
            default:          state_nx = ST_RD_A;
          endcase
        end
        ST_RST_WR: if (wr_ack) begin
          state_nx = ST_IDLE;
          fail_nx  = 1'b1;
        end
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      confirming <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      state      <= state_nx;
      confirming <= conf_nx;
      done       <= done_nx;
      fail       <= fail_nx;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !abort |=> rd_req) else $error("read request dropped"); // R3
  AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !abort |=> rd_req) else $error("start ignored"); // R2
  AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_req && rd_ack) && !busy) else $error("done without read"); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack && !abort |=> wr_req) else $error("write request dropped"); // R7
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req)) else $error("read and write together"); // R7
  AST_FAIL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(wr_req && wr_ack)) else $error("fail without write"); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)) else $error("done and fail together"); // R8
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than a cycle"); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !rd_req && !wr_req && !confirming) else $error("abort not honoured"); // R9

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpc_pkg::*;
#(
  parameter int unsigned   DW         = 8,
  parameter int unsigned   AW         = 16,
  parameter int unsigned   TOGGLE_SEL = 6,
  parameter int unsigned   LIMIT_SEL  = 5,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  parameter logic [DW-1:0] RESET_CMD  = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  output logic          rd_req,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  input  logic          wr_ack,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done,
  output logic          fail
);
  logic         first_bit, first_valid, cur_bit, cur_limit;
  logic         confirming, cap_first, cap_second, clear;
  tpc_verdict_e verdict;

  tpc_sample #(.DW(DW), .TOGGLE_SEL(TOGGLE_SEL), .LIMIT_SEL(LIMIT_SEL)) u_sample (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .cap_first(cap_first), .cap_second(cap_second), .rd_data(rd_data),
    .first_bit(first_bit), .first_valid(first_valid),
    .cur_bit(cur_bit), .cur_limit(cur_limit)
  );

  assign verdict = judge_pair(first_bit, cur_bit, cur_limit, confirming);

  tpc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .rd_ack(rd_ack), .wr_ack(wr_ack), .verdict(verdict),
    .rd_req(rd_req), .wr_req(wr_req), .busy(busy),
    .done(done), .fail(fail), .confirming(confirming),
    .cap_first(cap_first), .cap_second(cap_second), .clear(clear)
  );

  assign wr_addr = RESET_ADDR;
  assign wr_data = RESET_CMD;

  AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |-> !$isunknown(rd_data)) else $error("unknown read data"); // R3
  AST_WR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(rd_req && rd_ack && confirming)) else $error("write without confirm"); // R7

endmodule

// File: tb/sim_toggle_poll_ctrl.sv
module sim_toggle_poll_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, start, abort, rd_ack, wr_ack;
  logic [7:0] rd_data;
  logic       rd_req, wr_req, busy, done, fail;
  logic [15:0] wr_addr;
  logic [7:0] wr_data;
  logic       rd_req1, wr_req1, busy1, done1, fail1;
  logic [15:0] wr_addr1;
  logic [7:0] wr_data1;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  toggle_poll_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .fail(fail));

  toggle_poll_ctrl #(.TOGGLE_SEL(2)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .rd_req(rd_req1), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req1), .wr_ack(wr_ack), .wr_addr(wr_addr1), .wr_data(wr_data1),
    .busy(busy1), .done(done1), .fail(fail1));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bit6 and bit2 carry toggle values, bit5 the time-limit flag
  function automatic logic [7:0] mk2(input logic t6, input logic t2, input logic lim);
    return {1'b0, t6, lim, 2'b00, t2, 2'b00};
  endfunction
  function automatic logic [7:0] mk(input logic t, input logic lim);
    return mk2(t, t, lim);
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    check("R9", "busy after abort", busy, 0);
    check("R9", "rd_req after abort", rd_req, 0);
    check("R9", "wr_req after abort", wr_req, 0);
  endtask

  task automatic serve_read(input logic [7:0] d, input int lat);
    int w = 0;
    while (!rd_req && w < 20) begin @(negedge clk); w++; end
    check("R3", "read requested", rd_req, 1);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check("R3", "rd_req held", rd_req, 1);
    end
    rd_ack = 1'b1; rd_data = d;
    @(negedge clk);
    rd_ack = 1'b0; rd_data = 8'h00;
  endtask

  task automatic serve_write(input int lat);
    check("R7", "wr_req raised", wr_req, 1);
    check("R7", "wr_addr", wr_addr, 32'h0);
    check("R7", "wr_data", wr_data, 32'hF0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check("R7", "wr_req held", wr_req, 1);
      check("R7", "no read during write", rd_req, 0);
    end
    wr_ack = 1'b1;
    @(negedge clk);
    wr_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "rd_req", rd_req, 0);
    check("R1", "wr_req", wr_req, 0);
    check("R1", "done", done, 0);
    check("R1", "fail", fail, 0);
    check("R1", "busy", busy, 0);
  endtask

  task automatic t_quick_done();
    pulse_start();
    check("R2", "busy after start", busy, 1);
    check("R2", "rd_req after start", rd_req, 1);
    serve_read(mk(1'b0, 1'b0), 2);
    check("R3", "no decision after one read", done, 0);
    serve_read(mk(1'b0, 1'b1), 0);
    check("R4", "done after equal pair", done, 1);
    check("R4", "idle with done", busy, 0);
    @(negedge clk);
    check("R8", "done single cycle", done, 0);
    check("R4", "no further read", rd_req, 0);
  endtask

  task automatic t_repoll();
    pulse_start();
    serve_read(mk(1'b0, 1'b0), 1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    serve_read(mk(1'b1, 1'b0), 0);
    check("R5", "new pair requested", rd_req, 1);
    check("R5", "no done on toggle", done, 0);
    check("R2", "start while busy ignored", busy, 1);
    serve_read(mk(1'b0, 1'b0), 0);
    serve_read(mk(1'b1, 1'b0), 0);
    check("R5", "still polling", rd_req, 1);
    check("R5", "no write", wr_req, 0);
    serve_read(mk(1'b1, 1'b0), 0);
    serve_read(mk(1'b1, 1'b0), 0);
    check("R4", "done after repolls", done, 1);
  endtask

  task automatic t_confirm_ok();
    pulse_start();
    serve_read(mk(1'b0, 1'b0), 0);
    serve_read(mk(1'b1, 1'b1), 0);
    check("R6", "confirm pair requested", rd_req, 1);
    check("R6", "no done yet", done, 0);
    serve_read(mk(1'b0, 1'b1), 0);
    serve_read(mk(1'b0, 1'b1), 0);
    check("R6", "done after confirm", done, 1);
    check("R6", "no fail", fail, 0);
  endtask

  task automatic t_confirm_fail();
    pulse_start();
    serve_read(mk(1'b0, 1'b0), 0);
    serve_read(mk(1'b1, 1'b1), 0);
    serve_read(mk(1'b1, 1'b1), 0);
    serve_read(mk(1'b0, 1'b1), 0);
    check("R7", "no read after confirm toggle", rd_req, 0);
    serve_write(2);
    check("R8", "fail after write", fail, 1);
    check("R8", "no done with fail", done, 0);
    check("R7", "idle after write", busy, 0);
    @(negedge clk);
    check("R8", "fail single cycle", fail, 0);
  endtask

  task automatic t_limit_latest();
    pulse_start();
    serve_read(mk(1'b0, 1'b1), 0);
    serve_read(mk(1'b1, 1'b0), 0);
    serve_read(mk(1'b0, 1'b0), 0);
    serve_read(mk(1'b1, 1'b0), 0);
    check("R6", "limit bit from latest read only", rd_req, 1);
    check("R6", "no reset write", wr_req, 0);
    serve_read(mk(1'b1, 1'b0), 0);
    serve_read(mk(1'b1, 1'b0), 0);
    check("R4", "done ends pass", done, 1);
  endtask

  task automatic t_abort();
    pulse_start();
    serve_read(mk(1'b0, 1'b0), 0);
    serve_read(mk(1'b1, 1'b1), 0);
    serve_read(mk(1'b1, 1'b0), 0);
    do_abort();
    pulse_start();
    serve_read(mk(1'b0, 1'b0), 0);
    check("R9", "fresh pass needs two reads", rd_req, 1);
    check("R9", "no done after one read", done, 0);
    serve_read(mk(1'b1, 1'b0), 0);
    check("R9", "confirm state cleared", wr_req, 0);
    check("R9", "repoll after abort", rd_req, 1);
    serve_read(mk(1'b1, 1'b0), 0);
    serve_read(mk(1'b1, 1'b0), 0);
    check("R9", "done after restart", done, 1);
  endtask

  task automatic t_select();
    pulse_start();
    serve_read(mk2(1'b0, 1'b0, 1'b0), 0);
    serve_read(mk2(1'b0, 1'b1, 1'b0), 0);
    check("R10", "bit 6 steady gives done", done, 1);
    check("R10", "bit 2 variant repolls", rd_req1, 1);
    check("R10", "bit 2 variant no done", done1, 0);
    do_abort();
    pulse_start();
    serve_read(mk2(1'b0, 1'b1, 1'b0), 0);
    serve_read(mk2(1'b1, 1'b1, 1'b0), 0);
    check("R10", "bit 2 steady gives done", done1, 1);
    check("R10", "bit 6 variant repolls", rd_req, 1);
    do_abort();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; abort = 1'b0;
    rd_ack = 1'b0; wr_ack = 1'b0; rd_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quick_done();
    t_repoll();
    t_confirm_ok();
    t_confirm_fail();
    t_limit_latest();
    t_abort();
    t_select();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule